// File: doc/BRIEF.md
# 10BASE-T Transmit Supervisor

This block watches over a 10 Mb/s twisted-pair port at the digital level. It has three jobs. First, it follows link health from received link-pulse and receive-activity strobes. When the line stays silent too long, it declares the link lost and asks for auto-negotiation to restart. Second, after every transmitted packet it can send the heartbeat (SQE) pulse on the collision output. Third, it guards against a stuck transmitter. A packet that runs past a time limit locks out both the transmit path and the loopback path. The lockout is released on its own after a fixed quiet interval.

All timing is counted in ticks of a bit-time clock enable, `bit_tick`. Each of the three functions has its own configuration input:

- one input switches off the link integrity test, which also lets packets through whatever the link state is;
- one input turns the heartbeat on;
- one input switches off jabber protection.

The transmit and loopback enables are plain gates derived from the transmit-enable of the packet in flight. Line coding and the negotiation handshake are outside this block.

Top module: `tp10_supervisor`

## Requirements
- R1: After reset, `link_up`, `an_restart`, `col` and `jabber_flag` are all 0.
- R2: A `link_pulse` or `rx_activity` strobe sampled at a clock edge makes `link_up` 1 from that edge on, and restarts the silence count.
- R3: With the integrity test on, `link_up` falls after `LINK_TIMEOUT_TICKS` ticks with no link pulse or activity. On that same edge, `an_restart` pulses high for exactly one clock if `cfg_autoneg_on` is 1, and stays low otherwise.
- R4: With `cfg_integrity_off` = 1, the silence timeout never fires and `tx_gate` does not depend on `link_up`.
- R5: `tx_gate` is 1 exactly when `tx_en` is 1, `jabber_flag` is 0, and either `link_up` or `cfg_integrity_off` is 1.
- R6: While `cfg_sqe_on` is 0 (its reset state), `col` stays 0.
- R7: With `cfg_sqe_on` = 1, a falling edge of `tx_en` starts a wait of `SQE_DELAY_TICKS` ticks. `col` then stays high for exactly `SQE_WIDTH_TICKS` ticks; the width is to be set between 5 and 15 bit times.
- R8: When `tx_en` stays high for `JABBER_LIMIT_TICKS` ticks, `jabber_flag` goes to 1 and both `tx_gate` and `lb_gate` go to 0.
- R9: `jabber_flag` clears by itself `UNJABBER_TICKS` ticks after it was set.
- R10: With `cfg_jabber_off` = 1, `jabber_flag` stays 0 however long `tx_en` is held.
- R11: `lb_gate` is 1 exactly when `tx_en` is 1 and `jabber_flag` is 0.
- R12: A rising edge of `tx_en` during the heartbeat wait or pulse cancels it; `col` drops or stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | Bit-time clock enable |
| link_pulse | input | 1 | Strobe for a received link pulse |
| rx_activity | input | 1 | Strobe for received packet activity |
| tx_en | input | 1 | Transmit-enable of the current packet |
| cfg_integrity_off | input | 1 | 1 switches off the link integrity test |
| cfg_sqe_on | input | 1 | 1 turns on the heartbeat |
| cfg_jabber_off | input | 1 | 1 switches off jabber protection |
| cfg_autoneg_on | input | 1 | Auto-negotiation enabled |
| link_up | output | 1 | Link declared good |
| an_restart | output | 1 | One-clock request to restart auto-negotiation |
| col | output | 1 | Collision output carrying the heartbeat |
| tx_gate | output | 1 | Transmit path enable |
| lb_gate | output | 1 | Loopback path enable |
| jabber_flag | output | 1 | Jabber lockout active |

## Verification
A stale silence counter shows up as `link_up` falling, or an `an_restart` pulse arriving, one or more ticks away from the expected edge. A wrong jabber run count shifts the edge where `tx_gate` and `lb_gate` close, and a wrong release count shifts the edge where they reopen. A miscounting heartbeat state moves the start of `col` or changes its length in ticks. Every one of these errors is visible within one clock of the edge where it happens. The bench therefore compares all six outputs against a behavioural model on every clock, and adds directed checks on tick counts and pulse counts.

// File: rtl/tp10_pkg.sv
package tp10_pkg;
  typedef enum logic [1:0] {
    HB_IDLE  = 2'd0,
    HB_WAIT  = 2'd1,
    HB_PULSE = 2'd2
  } hb_state_e;

  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/tp10_link_monitor.sv
module tp10_link_monitor #(
  parameter int TIMEOUT_TICKS = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic link_pulse,
  input  logic rx_activity,
  input  logic integrity_off,
  input  logic autoneg_on,
  output logic link_up,
  output logic an_restart
);
  localparam int W = tp10_pkg::cnt_bits(TIMEOUT_TICKS);
  localparam logic [W-1:0] LAST = W'(TIMEOUT_TICKS - 1);

  logic [W-1:0] silence_q;
  logic         link_q;
  logic         an_q;
  logic         heard;

  assign heard = link_pulse | rx_activity;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      silence_q <= '0;
      link_q    <= 1'b0;
      an_q      <= 1'b0;
    end else begin
      an_q <= 1'b0;
      if (heard) begin
        link_q    <= 1'b1;
        silence_q <= '0;
      end else if (integrity_off) begin
        silence_q <= '0;
      end else if (bit_tick && link_q) begin
        if (silence_q == LAST) begin
          link_q    <= 1'b0;
          silence_q <= '0;
          an_q      <= autoneg_on;
        end else begin
          silence_q <= silence_q + W'(1);
        end
      end
    end
  end

  assign link_up    = link_q;
  assign an_restart = an_q;
endmodule

// File: rtl/tp10_heartbeat.sv
module tp10_heartbeat #(
  parameter int DELAY_TICKS = 6,
  parameter int WIDTH_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic tx_en,
  input  logic sqe_on,
  output logic col
);
  import tp10_pkg::*;

  localparam int W = cnt_bits(max2(DELAY_TICKS, WIDTH_TICKS));
  localparam logic [W-1:0] DLY_LAST = W'(DELAY_TICKS - 1);
  localparam logic [W-1:0] WID_LAST = W'(WIDTH_TICKS - 1);

  hb_state_e    state_q;
  logic [W-1:0] cnt_q;
  logic         tx_prev_q;
  logic         tx_rise;
  logic         tx_fall;

  assign tx_rise = tx_en & ~tx_prev_q;
  assign tx_fall = ~tx_en & tx_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= HB_IDLE;
      cnt_q     <= '0;
      tx_prev_q <= 1'b0;
    end else begin
      tx_prev_q <= tx_en;
      if (!sqe_on || tx_rise) begin
        state_q <= HB_IDLE;
        cnt_q   <= '0;
      end else if (tx_fall) begin
        state_q <= HB_WAIT;
        cnt_q   <= '0;
      end else if (bit_tick) begin
        case (state_q)
          HB_WAIT: begin
            if (cnt_q == DLY_LAST) begin
              state_q <= HB_PULSE;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + W'(1);
            end
          end
          HB_PULSE: begin
            if (cnt_q == WID_LAST) begin
              state_q <= HB_IDLE;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + W'(1);
            end
          end
          default: cnt_q <= '0;
        endcase
      end
    end
  end

  assign col = (state_q == HB_PULSE);
endmodule

// File: rtl/tp10_jabber_guard.sv
module tp10_jabber_guard #(
  parameter int LIMIT_TICKS   = 200_000,
  parameter int RELEASE_TICKS = 5_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic tx_en,
  input  logic jabber_off,
  output logic jabbering
);
  localparam int W = tp10_pkg::cnt_bits(tp10_pkg::max2(LIMIT_TICKS, RELEASE_TICKS));
  localparam logic [W-1:0] LIM_LAST = W'(LIMIT_TICKS - 1);
  localparam logic [W-1:0] REL_LAST = W'(RELEASE_TICKS - 1);

  logic [W-1:0] cnt_q;
  logic         jab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      jab_q <= 1'b0;
    end else if (jabber_off) begin
      cnt_q <= '0;
      jab_q <= 1'b0;
    end else if (jab_q) begin
      if (bit_tick) begin
        if (cnt_q == REL_LAST) begin
          jab_q <= 1'b0;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + W'(1);
        end
      end
    end else if (tx_en) begin
      if (bit_tick) begin
        if (cnt_q == LIM_LAST) begin
          jab_q <= 1'b1;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + W'(1);
        end
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign jabbering = jab_q;
endmodule

// File: rtl/tp10_supervisor.sv
module tp10_supervisor #(
  parameter int LINK_TIMEOUT_TICKS = 1_000_000,
  parameter int JABBER_LIMIT_TICKS = 200_000,
  parameter int UNJABBER_TICKS     = 5_000_000,
  parameter int SQE_DELAY_TICKS    = 6,
  parameter int SQE_WIDTH_TICKS    = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic link_pulse,
  input  logic rx_activity,
  input  logic tx_en,
  input  logic cfg_integrity_off,
  input  logic cfg_sqe_on,
  input  logic cfg_jabber_off,
  input  logic cfg_autoneg_on,
  output logic link_up,
  output logic an_restart,
  output logic col,
  output logic tx_gate,
  output logic lb_gate,
  output logic jabber_flag
);
  logic jab;
  logic link_ok;

  tp10_link_monitor #(.TIMEOUT_TICKS(LINK_TIMEOUT_TICKS)) u_link (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_tick     (bit_tick),
    .link_pulse   (link_pulse),
    .rx_activity  (rx_activity),
    .integrity_off(cfg_integrity_off),
    .autoneg_on   (cfg_autoneg_on),
    .link_up      (link_ok),
    .an_restart   (an_restart)
  );

  tp10_heartbeat #(.DELAY_TICKS(SQE_DELAY_TICKS), .WIDTH_TICKS(SQE_WIDTH_TICKS)) u_hb (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_tick(bit_tick),
    .tx_en   (tx_en),
    .sqe_on  (cfg_sqe_on),
    .col     (col)
  );

  tp10_jabber_guard #(.LIMIT_TICKS(JABBER_LIMIT_TICKS), .RELEASE_TICKS(UNJABBER_TICKS)) u_jab (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .tx_en     (tx_en),
    .jabber_off(cfg_jabber_off),
    .jabbering (jab)
  );

  assign link_up     = link_ok;
  assign jabber_flag = jab;
  assign tx_gate     = tx_en & ~jab & (link_ok | cfg_integrity_off);
  assign lb_gate     = tx_en & ~jab;
endmodule

// File: rtl/tp10_supervisor_chk.sv
module tp10_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic link_pulse,
  input logic rx_activity,
  input logic tx_en,
  input logic cfg_integrity_off,
  input logic cfg_sqe_on,
  input logic cfg_jabber_off,
  input logic link_up,
  input logic an_restart,
  input logic col,
  input logic tx_gate,
  input logic lb_gate,
  input logic jabber_flag
);
  assert_link_on_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(link_pulse || rx_activity) |-> link_up);

  assert_an_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    an_restart |=> !an_restart);

  assert_an_with_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    an_restart |-> !link_up);

  assert_tx_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !cfg_integrity_off && !link_up) |-> !tx_gate);

  assert_col_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_sqe_on && $past(!cfg_sqe_on)) |-> !col);

  assert_jabber_gates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    jabber_flag |-> (!tx_gate && !lb_gate));

  assert_jabber_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_jabber_off) |-> !jabber_flag);

  assert_lb_follows_tx_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lb_gate |-> tx_en);

  assert_rise_cancels_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tx_en) && $past(tx_en, 2)) |-> !col);
endmodule

bind tp10_supervisor tp10_supervisor_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .link_pulse       (link_pulse),
  .rx_activity      (rx_activity),
  .tx_en            (tx_en),
  .cfg_integrity_off(cfg_integrity_off),
  .cfg_sqe_on       (cfg_sqe_on),
  .cfg_jabber_off   (cfg_jabber_off),
  .link_up          (link_up),
  .an_restart       (an_restart),
  .col              (col),
  .tx_gate          (tx_gate),
  .lb_gate          (lb_gate),
  .jabber_flag      (jabber_flag)
);

// File: tb/tp10_supervisor_test.sv
`timescale 1ns/1ps
module tp10_supervisor_test;
  localparam int LTO = 40;
  localparam int JL  = 60;
  localparam int UJ  = 100;
  localparam int DLY = 3;
  localparam int WID = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0, link_pulse = 1'b0, rx_activity = 1'b0, tx_en = 1'b0;
  logic cfg_integrity_off = 1'b0, cfg_sqe_on = 1'b0, cfg_jabber_off = 1'b0, cfg_autoneg_on = 1'b0;
  logic link_up, an_restart, col, tx_gate, lb_gate, jabber_flag;

  always #2.5 clk = ~clk;

  tp10_supervisor #(
    .LINK_TIMEOUT_TICKS(LTO), .JABBER_LIMIT_TICKS(JL), .UNJABBER_TICKS(UJ),
    .SQE_DELAY_TICKS(DLY), .SQE_WIDTH_TICKS(WID)
  ) uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .link_pulse(link_pulse),
    .rx_activity(rx_activity), .tx_en(tx_en), .cfg_integrity_off(cfg_integrity_off),
    .cfg_sqe_on(cfg_sqe_on), .cfg_jabber_off(cfg_jabber_off), .cfg_autoneg_on(cfg_autoneg_on),
    .link_up(link_up), .an_restart(an_restart), .col(col), .tx_gate(tx_gate),
    .lb_gate(lb_gate), .jabber_flag(jabber_flag)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit pulses_on = 1'b0;
  int cyc = 0;
  int an_count = 0;
  int col_ticks = 0;
  bit seen_col = 1'b0;

  // reference model state
  int  m_sil = 0, m_jcnt = 0, m_age = -1;
  bit  m_link = 0, m_an = 0, m_jab = 0, m_prev = 0;

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // background drivers: tick two of every three cycles, periodic link pulses
  always @(posedge clk) begin
    #1;
    cyc++;
    bit_tick   = (cyc % 3) != 0;
    link_pulse = pulses_on && ((cyc % 16) == 0);
  end

  // reference model, updated on the same edges as the design
  always @(posedge clk) begin
    if (!rst_n) begin
      m_sil = 0; m_jcnt = 0; m_age = -1;
      m_link = 0; m_an = 0; m_jab = 0; m_prev = 0;
    end else begin
      m_an = 0;
      if (link_pulse || rx_activity) begin
        m_link = 1; m_sil = 0;
      end else if (cfg_integrity_off) begin
        m_sil = 0;
      end else if (bit_tick && m_link) begin
        m_sil++;
        if (m_sil == LTO) begin
          m_link = 0; m_sil = 0; m_an = cfg_autoneg_on;
        end
      end
      if (cfg_jabber_off) begin
        m_jab = 0; m_jcnt = 0;
      end else if (m_jab) begin
        if (bit_tick) begin
          m_jcnt++;
          if (m_jcnt == UJ) begin m_jab = 0; m_jcnt = 0; end
        end
      end else if (tx_en) begin
        if (bit_tick) begin
          m_jcnt++;
          if (m_jcnt == JL) begin m_jab = 1; m_jcnt = 0; end
        end
      end else begin
        m_jcnt = 0;
      end
      if (!cfg_sqe_on || (tx_en && !m_prev)) m_age = -1;
      else if (m_prev && !tx_en) m_age = 0;
      else if (m_age >= 0 && bit_tick) begin
        m_age++;
        if (m_age == DLY + WID) m_age = -1;
      end
      m_prev = tx_en;
    end
  end

  // per-clock comparison and event counters, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2/R3 link_up", link_up, m_link);
      check("R3 an_restart", an_restart, m_an);
      check("R7 col", col, m_age >= DLY);
      check("R5 tx_gate", tx_gate, tx_en && !m_jab && (m_link || cfg_integrity_off));
      check("R11 lb_gate", lb_gate, tx_en && !m_jab);
      check("R8/R9 jabber_flag", jabber_flag, m_jab);
      if (an_restart) an_count++;
      if (col) seen_col = 1'b1;
      if (col && bit_tick) col_ticks++;
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
    end
  end

  initial begin
    step(4);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 link_up reset", link_up, 1'b0);
    check("R1 an_restart reset", an_restart, 1'b0);
    check("R1 col reset", col, 1'b0);
    check("R1 jabber reset", jabber_flag, 1'b0);

    // R5: no link, integrity test on -> transmit blocked
    step(1); tx_en = 1'b1;
    step(5);
    @(negedge clk);
    check("R5 tx blocked without link", tx_gate, 1'b0);
    check("R11 loopback open", lb_gate, 1'b1);
    step(1); tx_en = 1'b0;

    // R2: activity strobe brings the link up
    step(3); rx_activity = 1'b1;
    step(1); rx_activity = 1'b0;
    @(negedge clk);
    check("R2 link after activity", link_up, 1'b1);
    step(1); pulses_on = 1'b1;

    // R6: heartbeat off, a packet ends, col stays low
    seen_col = 1'b0;
    step(5); tx_en = 1'b1;
    step(20); tx_en = 1'b0;
    step(30);
    check("R6 no heartbeat when off", seen_col, 1'b0);

    // R7: heartbeat on, pulse length counted in ticks
    cfg_sqe_on = 1'b1;
    step(2); tx_en = 1'b1; seen_col = 1'b0; col_ticks = 0;
    step(25); tx_en = 1'b0;
    step(35);
    check("R7 heartbeat seen", seen_col, 1'b1);
    check_int("R7 heartbeat width ticks", col_ticks, WID);

    // R12: transmit restarts during the wait -> heartbeat cancelled
    tx_en = 1'b1;
    step(20); tx_en = 1'b0; seen_col = 1'b0;
    step(2); tx_en = 1'b1;
    step(20);
    check("R12 heartbeat cancelled", seen_col, 1'b0);
    tx_en = 1'b0;
    step(30);
    cfg_sqe_on = 1'b0;

    // R3: silence with auto-negotiation on
    cfg_autoneg_on = 1'b1; an_count = 0;
    pulses_on = 1'b0;
    step(100);
    @(negedge clk);
    check("R3 link lost after silence", link_up, 1'b0);
    check_int("R3 one restart request", an_count, 1);

    // R3: silence with auto-negotiation off -> no request
    step(1); pulses_on = 1'b1; cfg_autoneg_on = 1'b0;
    step(20); pulses_on = 1'b0; an_count = 0;
    step(100);
    @(negedge clk);
    check("R3 link lost, autoneg off", link_up, 1'b0);
    check_int("R3 no restart request", an_count, 0);

    // R4: integrity test off -> no timeout and transmit allowed
    step(1); cfg_integrity_off = 1'b1;
    step(5);
    @(negedge clk);
    step(1); tx_en = 1'b1;
    @(negedge clk);
    check("R4 tx allowed with link down", tx_gate, 1'b1);
    step(1); tx_en = 1'b0; pulses_on = 1'b1;
    step(20); pulses_on = 1'b0;
    step(150);
    @(negedge clk);
    check("R4 no timeout when test off", link_up, 1'b1);

    // R8: transmit held too long -> jabber lockout
    step(1); tx_en = 1'b1;
    step(110);
    @(negedge clk);
    check("R8 jabber set", jabber_flag, 1'b1);
    check("R8 tx closed", tx_gate, 1'b0);
    check("R8 loopback closed", lb_gate, 1'b0);

    // R9: automatic release
    step(1); tx_en = 1'b0;
    step(60);
    @(negedge clk);
    check("R9 still locked mid interval", jabber_flag, 1'b1);
    step(100);
    @(negedge clk);
    check("R9 released", jabber_flag, 1'b0);

    // R10: protection disabled -> long transmit never jabbers
    step(1); cfg_jabber_off = 1'b1; tx_en = 1'b1;
    step(200);
    @(negedge clk);
    check("R10 no jabber when off", jabber_flag, 1'b0);
    check("R10 tx still open", tx_gate, 1'b1);
    step(1); tx_en = 1'b0;
    step(10);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule